// File: doc/BRIEF.md
# Data-Enable Recovery for Sync-Only Parallel Video

This block sits between a parallel RGB video source and a TMDS encoder. The source supplies a pixel clock, horizontal sync, vertical sync and 24 bits of colour, but no data-enable. A TMDS encoder sends control symbols built from the two sync bits whenever data-enable is low. It therefore needs a clean active-video flag that is low through every blanking interval.

The block measures position inside the raster from the leading edges of the incoming syncs. A pixel counter restarts at each horizontal sync rising edge. A line counter restarts at the line on which vertical sync is first seen active at a horizontal sync edge. Data-enable is high only where both counts fall inside their programmable active windows. Colour, syncs and data-enable leave through the same two register stages, so they stay aligned.

A lock monitor compares each measured line length and frame length with the expected totals. After any mismatch, and out of reset, it holds data-enable low until two consecutive frames measure correctly. Sync polarity, porch, sync and active lengths are parameters. The defaults describe 1280x720 at 60 Hz with a 74.25 MHz pixel clock: 1650 clocks per line and 750 lines per frame.

Top module: `sync_de_recover`

## Requirements
- R1: red_o, green_o, blue_o, hsync_o and vsync_o repeat red_i, green_i, blue_i, hsync_i and vsync_i unchanged, exactly two clock cycles later.
- R2: Number the clocks of a line with k = 0 on the clock where horizontal sync is first seen active. While unlocked-free and inside an active line, de_o is high for exactly the pixels with H_SYNC+H_BACK <= k < H_SYNC+H_BACK+H_ACTIVE. It appears with the same two-cycle delay as the pixel data.
- R3: Number the lines with L = 0 on the line whose horizontal sync edge first sees vertical sync active. Only lines with V_SYNC+V_BACK <= L < V_SYNC+V_BACK+V_ACTIVE can carry de_o high.
- R4: de_o is never high for a pixel that lies in a horizontal or vertical sync, porch or blanking line.
- R5: While rst_ni is low, and on the first cycle after it rises, de_o, the colour outputs and the sync outputs are 0 and lock_err_o is 1.
- R6: A line whose length, measured between horizontal sync rising edges, differs from H_SYNC+H_BACK+H_ACTIVE+H_FRONT sets lock_err_o. This becomes visible at the output together with the pixel that carries the closing edge. The setting is the same when that edge also starts a new frame.
- R7: A frame whose line count, measured between vertical sync line edges, differs from V_SYNC+V_BACK+V_ACTIVE+V_FRONT sets lock_err_o. This becomes visible at the output together with the closing frame edge pixel.
- R8: While lock_err_o is 1, de_o stays 0. lock_err_o clears at the frame edge that completes the second consecutive frame whose frame length and all line lengths were correct. The frame opened after reset counts as the first measurable frame, so data-enable first appears in the third frame after reset.
- R9: On the first cycle that de_o is high in a line, the colour outputs carry the first active pixel of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync, polarity set by HS_ACTIVE_HIGH |
| vsync_i | input | 1 | Vertical sync, polarity set by VS_ACTIVE_HIGH |
| red_i | input | 8 | Red component |
| green_i | input | 8 | Green component |
| blue_i | input | 8 | Blue component |
| red_o | output | 8 | Red, delayed two cycles |
| green_o | output | 8 | Green, delayed two cycles |
| blue_o | output | 8 | Blue, delayed two cycles |
| hsync_o | output | 1 | Horizontal sync, delayed two cycles, input polarity |
| vsync_o | output | 1 | Vertical sync, delayed two cycles, input polarity |
| de_o | output | 1 | Recovered data-enable, aligned with the colour outputs |
| lock_err_o | output | 1 | High while timing is not confirmed |

## Verification
The assertions assume a source whose sync pulses never overlap its active region. They also assume that lines, once locked, are never cut short inside the active window. Under that assumption, a data-enable run must be exactly the active width and must never coincide with an active sync output. The bench keeps to these assumptions: every stimulus line it builds has intact sync, back porch and active sections. Timing faults are introduced only by removing one front-porch pixel or one trailing blanking line, so the active window is never cut.

// File: rtl/dr_pkg.sv
package dr_pkg;

    localparam int COLOR_W = 8;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] green;
        logic [COLOR_W-1:0] blue;
    } pixel_t;

    typedef struct packed {
        pixel_t pix;
        logic   hs;
        logic   vs;
        logic   de;
    } vid_t;

    // true when lo <= val < lo + len
    function automatic logic in_window(input int unsigned val,
                                       input int unsigned lo,
                                       input int unsigned len);
        return (val >= lo) && (val < lo + len);
    endfunction

endpackage

// File: rtl/dr_hcount.sv
module dr_hcount #(
    parameter int H_SYNC   = 40,
    parameter int H_BACK   = 220,
    parameter int H_ACTIVE = 1280,
    parameter int H_TOTAL  = 1650
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic edge_i,
    output logic act_o,
    output logic len_chk_o,
    output logic len_ok_o
);
    localparam int W = $clog2(H_TOTAL + 1) + 1;
    localparam logic [W-1:0] CMAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         seen;
    } hst_t;

    hst_t st_d, st_q;
    logic [W-1:0] cur;

    always_comb begin
        st_d = st_q;
        if (edge_i)
            cur = '0;
        else if (st_q.cnt == CMAX)
            cur = CMAX;
        else
            cur = st_q.cnt + 1'b1;
        st_d.cnt  = cur;
        st_d.seen = st_q.seen | edge_i;
        act_o     = dr_pkg::in_window(32'(cur), 32'(H_SYNC + H_BACK), 32'(H_ACTIVE));
        len_chk_o = edge_i & st_q.seen;
        len_ok_o  = (32'(st_q.cnt) + 32'd1) == 32'(H_TOTAL);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt  <= CMAX;
            st_q.seen <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dr_vcount.sv
module dr_vcount #(
    parameter int V_SYNC   = 5,
    parameter int V_BACK   = 20,
    parameter int V_ACTIVE = 720,
    parameter int V_TOTAL  = 750
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_evt_i,
    input  logic vs_i,
    output logic act_o,
    output logic frame_evt_o,
    output logic frame_chk_o,
    output logic frame_ok_o
);
    localparam int W = $clog2(V_TOTAL + 1) + 1;
    localparam logic [W-1:0] CMAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         vs_prev;
        logic         seen;
        logic         act;
    } vst_t;

    vst_t st_d, st_q;
    logic [W-1:0] nxt;
    logic         vs_edge;

    always_comb begin
        st_d    = st_q;
        vs_edge = line_evt_i & vs_i & ~st_q.vs_prev;
        if (vs_edge)
            nxt = '0;
        else if (st_q.cnt == CMAX)
            nxt = CMAX;
        else
            nxt = st_q.cnt + 1'b1;
        if (line_evt_i) begin
            st_d.cnt     = nxt;
            st_d.vs_prev = vs_i;
            st_d.seen    = st_q.seen | vs_edge;
            st_d.act     = (st_q.seen | vs_edge) &
                           dr_pkg::in_window(32'(nxt), 32'(V_SYNC + V_BACK), 32'(V_ACTIVE));
        end
        act_o       = st_q.act;
        frame_evt_o = vs_edge;
        frame_chk_o = vs_edge & st_q.seen;
        frame_ok_o  = (32'(st_q.cnt) + 32'd1) == 32'(V_TOTAL);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt     <= CMAX;
            st_q.vs_prev <= 1'b0;
            st_q.seen    <= 1'b0;
            st_q.act     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dr_lock.sv
module dr_lock #(
    parameter int LOCK_FRAMES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_chk_i,
    input  logic line_ok_i,
    input  logic frame_evt_i,
    input  logic frame_chk_i,
    input  logic frame_ok_i,
    output logic err_o
);
    localparam int GW = $clog2(LOCK_FRAMES + 1);

    typedef struct packed {
        logic          err;
        logic          clean;
        logic [GW-1:0] good;
    } lst_t;

    lst_t st_d, st_q;
    logic line_bad;

    always_comb begin
        st_d     = st_q;
        line_bad = line_chk_i & ~line_ok_i;
        if (line_bad) begin
            st_d.err  = 1'b1;
            st_d.good = '0;
        end
        if (frame_evt_i) begin
            if (frame_chk_i) begin
                if (st_q.clean && !line_bad && frame_ok_i) begin
                    if (st_d.err) begin
                        if (st_q.good == GW'(LOCK_FRAMES - 1)) begin
                            st_d.err  = 1'b0;
                            st_d.good = '0;
                        end else begin
                            st_d.good = st_q.good + 1'b1;
                        end
                    end
                end else begin
                    st_d.err  = 1'b1;
                    st_d.good = '0;
                end
            end
            st_d.clean = 1'b1;
        end else if (line_bad) begin
            st_d.clean = 1'b0;
        end
        err_o = st_q.err;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.err   <= 1'b1;
            st_q.clean <= 1'b0;
            st_q.good  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sync_de_recover.sv
module sync_de_recover #(
    parameter int H_ACTIVE       = 1280,
    parameter int H_FRONT        = 110,
    parameter int H_SYNC         = 40,
    parameter int H_BACK         = 220,
    parameter int V_ACTIVE       = 720,
    parameter int V_FRONT        = 5,
    parameter int V_SYNC         = 5,
    parameter int V_BACK         = 20,
    parameter bit HS_ACTIVE_HIGH = 1'b1,
    parameter bit VS_ACTIVE_HIGH = 1'b1,
    parameter int LOCK_FRAMES    = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       hsync_i,
    input  logic       vsync_i,
    input  logic [7:0] red_i,
    input  logic [7:0] green_i,
    input  logic [7:0] blue_i,
    output logic [7:0] red_o,
    output logic [7:0] green_o,
    output logic [7:0] blue_o,
    output logic       hsync_o,
    output logic       vsync_o,
    output logic       de_o,
    output logic       lock_err_o
);
    import dr_pkg::*;

    localparam int H_TOTAL = H_SYNC + H_BACK + H_ACTIVE + H_FRONT;
    localparam int V_TOTAL = V_SYNC + V_BACK + V_ACTIVE + V_FRONT;

    typedef struct packed {
        vid_t s1;
        logic hs_prev;
        vid_t out;
    } top_t;

    top_t st_d, st_q;
    logic hs_n, vs_n, hs_edge;
    logic h_act, len_chk, len_ok;
    logic v_act, frame_evt, frame_chk, frame_ok;
    logic lock_err;

    dr_hcount #(
        .H_SYNC(H_SYNC), .H_BACK(H_BACK), .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL)
    ) u_hcount (
        .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(hs_edge),
        .act_o(h_act), .len_chk_o(len_chk), .len_ok_o(len_ok)
    );

    dr_vcount #(
        .V_SYNC(V_SYNC), .V_BACK(V_BACK), .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL)
    ) u_vcount (
        .clk_i(clk_i), .rst_ni(rst_ni), .line_evt_i(hs_edge), .vs_i(vs_n),
        .act_o(v_act), .frame_evt_o(frame_evt), .frame_chk_o(frame_chk),
        .frame_ok_o(frame_ok)
    );

    dr_lock #(
        .LOCK_FRAMES(LOCK_FRAMES)
    ) u_lock (
        .clk_i(clk_i), .rst_ni(rst_ni), .line_chk_i(len_chk), .line_ok_i(len_ok),
        .frame_evt_i(frame_evt), .frame_chk_i(frame_chk), .frame_ok_i(frame_ok),
        .err_o(lock_err)
    );

    always_comb begin
        st_d = st_q;
        // normalise to active-high for edge detection
        hs_n    = (st_q.s1.hs == HS_ACTIVE_HIGH);
        vs_n    = (st_q.s1.vs == VS_ACTIVE_HIGH);
        hs_edge = hs_n & ~st_q.hs_prev;

        st_d.s1.pix.red   = red_i;
        st_d.s1.pix.green = green_i;
        st_d.s1.pix.blue  = blue_i;
        st_d.s1.hs        = hsync_i;
        st_d.s1.vs        = vsync_i;
        st_d.s1.de        = 1'b0;
        st_d.hs_prev      = hs_n;

        st_d.out    = st_q.s1;
        st_d.out.de = h_act & v_act & ~lock_err;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q         <= '0;
            st_q.hs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign red_o      = st_q.out.pix.red;
    assign green_o    = st_q.out.pix.green;
    assign blue_o     = st_q.out.pix.blue;
    assign hsync_o    = st_q.out.hs;
    assign vsync_o    = st_q.out.vs;
    assign de_o       = st_q.out.de;
    assign lock_err_o = lock_err;

endmodule

// File: rtl/sync_de_recover_chk.sv
module sync_de_recover_chk #(
    parameter int H_ACTIVE       = 1280,
    parameter bit HS_ACTIVE_HIGH = 1'b1,
    parameter bit VS_ACTIVE_HIGH = 1'b1
) (
    input logic clk_i,
    input logic rst_ni,
    input logic de_o,
    input logic hsync_o,
    input logic vsync_o,
    input logic lock_err_o
);
    localparam int RW = $clog2(H_ACTIVE + 2) + 1;
    localparam logic [RW-1:0] RMAX = '1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            run_q <= '0;
        else if (de_o)
            run_q <= (run_q == RMAX) ? RMAX : run_q + 1'b1;
        else
            run_q <= '0;
    end

    // R4
    de_no_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        de_o |-> (hsync_o != HS_ACTIVE_HIGH) && (vsync_o != VS_ACTIVE_HIGH));

    // R2
    de_run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!de_o && $past(de_o)) |-> (32'(run_q) == H_ACTIVE));

    // R2
    de_max_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(run_q) <= H_ACTIVE);

    // R8
    de_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        de_o |-> $past(!lock_err_o));

    // R5
    reset_state_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!de_o && lock_err_o));

endmodule

bind sync_de_recover sync_de_recover_chk #(
    .H_ACTIVE(H_ACTIVE),
    .HS_ACTIVE_HIGH(HS_ACTIVE_HIGH),
    .VS_ACTIVE_HIGH(VS_ACTIVE_HIGH)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .de_o(de_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .lock_err_o(lock_err_o)
);

// File: tb/tb_sync_de_recover.sv
`timescale 1ns/1ps
module tb_sync_de_recover;
    localparam int HA = 8, HF = 2, HS = 2, HB = 3;
    localparam int VA = 4, VF = 1, VS = 1, VB = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n;
    logic       hs_i, vs_i;
    logic [7:0] r_i, g_i, b_i, r_o, g_o, b_o;
    logic       hs_o, vs_o, de_o, err_o;

    sync_de_recover #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs_i), .vsync_i(vs_i),
        .red_i(r_i), .green_i(g_i), .blue_i(b_i),
        .red_o(r_o), .green_o(g_o), .blue_o(b_o),
        .hsync_o(hs_o), .vsync_o(vs_o), .de_o(de_o), .lock_err_o(err_o)
    );

    typedef struct {
        logic        v;
        logic [23:0] rgb;
        logic        hs, vs, de, err, first;
        string       tag;
    } exp_t;

    int   checks = 0, errors = 0;
    bit   done = 1'b0;
    exp_t h0, h1;

    // bench reference of the lock rules
    int b_err = 1, b_good = 0, b_clean = 0, b_fstart = 0;
    int prev_len = 0, prev_lines = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] got,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", what, got, expv);
        end
    endtask

    task automatic compare_out();
        if (h1.v) begin
            chk({r_o, g_o, b_o} == h1.rgb, "R1 colour", {8'd0, r_o, g_o, b_o}, {8'd0, h1.rgb});
            chk(hs_o == h1.hs && vs_o == h1.vs, "R1 syncs", {30'd0, hs_o, vs_o},
                {30'd0, h1.hs, h1.vs});
            chk(de_o == h1.de, {h1.tag, " de"}, {31'd0, de_o}, {31'd0, h1.de});
            chk(err_o == h1.err, {h1.tag, " lock_err"}, {31'd0, err_o}, {31'd0, h1.err});
            if (h1.first)
                chk(de_o && {r_o, g_o, b_o} == h1.rgb, "R9 first active pixel",
                    {7'd0, de_o, r_o, g_o, b_o}, {8'd1, h1.rgb});
        end
    endtask

    task automatic drive(input logic hs, input logic vs, input logic [23:0] rgb,
                         input logic de, input logic first, input string tag);
        @(negedge clk);
        compare_out();
        h1 = h0;
        h0.v = 1'b1; h0.rgb = rgb; h0.hs = hs; h0.vs = vs;
        h0.de = de; h0.err = b_err[0]; h0.first = first; h0.tag = tag;
        hs_i = hs; vs_i = vs; {r_i, g_i, b_i} = rgb;
    endtask

    task automatic send_line(input int f, input int ln, input int len, input string tag);
        bit lbad;
        lbad = 1'b0;
        if (prev_len != 0 && prev_len != HT) begin
            b_err = 1; b_good = 0; lbad = 1'b1;
        end
        if (ln == 0) begin
            if (b_fstart != 0) begin
                if (b_clean != 0 && !lbad && prev_lines == VT) begin
                    if (b_err != 0) begin
                        if (b_good == 1) begin b_err = 0; b_good = 0; end
                        else b_good++;
                    end
                end else begin
                    b_err = 1; b_good = 0;
                end
            end
            b_fstart = 1; b_clean = 1;
        end else if (lbad) begin
            b_clean = 0;
        end
        for (int k = 0; k < len; k++) begin
            logic de_e, first_e;
            de_e = (b_err == 0) && (k >= HS + HB) && (k < HS + HB + HA) &&
                   (ln >= VS + VB) && (ln < VS + VB + VA);
            first_e = de_e && (k == HS + HB);
            drive(k < HS, ln < VS, {8'(f * 5 + 1), 8'(ln * 16 + k), 8'(k ^ ln ^ f)},
                  de_e, first_e, tag);
        end
        prev_len = len;
    endtask

    task automatic send_frame(input int f, input int short_ln, input int nlines,
                              input string tag);
        for (int ln = 0; ln < nlines; ln++)
            send_line(f, ln, (ln == short_ln) ? HT - 1 : HT, tag);
        prev_lines = nlines;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        h0.v = 1'b0; h1.v = 1'b0;
        rst_n = 1'b0; hs_i = 1'b0; vs_i = 1'b0; r_i = 8'h5a; g_i = 8'ha5; b_i = 8'h3c;
        repeat (4) @(negedge clk);
        // R5 reset state
        chk(de_o == 1'b0 && err_o == 1'b1, "R5 de/lock_err in reset",
            {30'd0, de_o, err_o}, 32'd1);
        chk({r_o, g_o, b_o, hs_o, vs_o} == 26'd0, "R5 outputs in reset",
            {6'd0, r_o, g_o, b_o, hs_o, vs_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(de_o == 1'b0 && err_o == 1'b1, "R5 first cycle after reset",
            {30'd0, de_o, err_o}, 32'd1);
        // clean start: data-enable first in the third frame (R2 R3 R4 R8)
        for (int f = 0; f < 4; f++) send_frame(f, -1, VT, "R2 R3 R4 R8");
        // short line inside the active area (R6)
        send_frame(4, 5, VT, "R6");
        for (int f = 5; f < 8; f++) send_frame(f, -1, VT, "R8");
        // frame one line short (R7)
        send_frame(8, -1, VT - 1, "R7");
        for (int f = 9; f < 12; f++) send_frame(f, -1, VT, "R7 R8");
        // short last line: line fault on a frame edge (R6)
        send_frame(12, VT - 1, VT, "R6");
        for (int f = 13; f < 16; f++) send_frame(f, -1, VT, "R6 R8");
        // flush the pipeline
        drive(1'b0, 1'b0, 24'd0, 1'b0, 1'b0, "R4");
        drive(1'b0, 1'b0, 24'd0, 1'b0, 1'b0, "R4");
        @(negedge clk);
        compare_out();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule